// File: doc/BRIEF.md
# Queue Occupancy Voltage/Frequency Level Controller

This block picks the operating point of a trailing core that runs the same program as a leading core and is fed by it through two forwarded queues: one carrying resolved branch directions and targets, one carrying load results. When both queues are filling up, the trailing core is falling behind and needs a faster operating point. When both are nearly drained, it is running faster than it needs to and can be slowed down to save energy. Any other combination leaves the point alone.

At a fixed sampling period the controller compares the two fill counts against a static upper and lower threshold. It then moves a level index one step up, one step down, or keeps it. The index goes to an external regulator and clock generator. After each change the controller marks itself busy for the settling time of that equipment and ignores samples until the settling time has passed. The sampling period and the settling time are given in nanoseconds and turned into cycle counts of a reference clock. By default there are six levels, 128-entry queues, a 1 µs sampling period and a 100 ns settling time at 100 MHz.

Top module: `occ_dvfs_ctrl`

## Requirements
- R1: During and right after reset, `level_o` equals `RESET_LEVEL` (default `NUM_LEVELS-1`, the fastest point) and `busy_o` is low.
- R2: Occupancies are looked at only once every `SAMPLE_CYC = REF_CLK_MHZ*SAMPLE_NS/1000` cycles. The first sample is taken on the `SAMPLE_CYC`-th rising edge after reset is released. Input values on the cycles in between have no effect.
- R3: If at a sample both fill counts are strictly greater than `THR_HI`, the level rises by one. The new index appears at the edge that takes the sample.
- R4: If at a sample both fill counts are strictly less than `THR_LO`, the level falls by one at the edge that takes the sample.
- R5: At a sample where neither R3 nor R4 applies the level is kept. This covers a count equal to a threshold and the case where the two queues disagree.
- R6: A rise requested at level `NUM_LEVELS-1` and a fall requested at level 0 are ignored: the level stays and `busy_o` stays low.
- R7: Each level change raises `busy_o` on the same edge. `busy_o` stays high for exactly `SETTLE_CYC = REF_CLK_MHZ*SETTLE_NS/1000` cycles.
- R8: Samples that fall while `busy_o` is high are ignored, and the level never changes while `busy_o` is high from the previous cycle.
- R9: `level_o` always stays in 0 to `NUM_LEVELS-1` and changes by exactly one step at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boq_occ_i | input | $clog2(QUEUE_DEPTH+1) | Fill count of the forwarded branch-result queue |
| lvq_occ_i | input | $clog2(QUEUE_DEPTH+1) | Fill count of the forwarded load-result queue |
| level_o | output | $clog2(NUM_LEVELS) | Operating level index, 0 slowest |
| busy_o | output | 1 | High while a level change is settling |

## Verification
A sample taken on a given rising edge shows up on `level_o` and `busy_o` right after that same edge. `busy_o` then drops `SETTLE_CYC` edges later. The bench keeps its own phase counter and settle counter from reset, advances them on every rising edge, and compares both outputs on every falling edge. It drives inputs only on falling edges, so every sample sees settled values. Directed sequences check the first sample at edge 20, the ignored sample at edge 40 while busy, and the next step at edge 60. They also walk the level to both ends, hold the counts exactly at each threshold, and hold the queues in disagreement.

// File: rtl/occ_dvfs_pkg.sv
package occ_dvfs_pkg;

    // Step request produced at a sample point
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Level controller mode
    typedef enum logic {
        MODE_IDLE   = 1'b0,
        MODE_SETTLE = 1'b1
    } mode_e;

    // Convert a duration in ns to reference clock cycles
    function automatic int ns_to_cycles(input int clk_mhz, input int dur_ns);
        return (clk_mhz * dur_ns) / 1000;
    endfunction

endpackage

// File: rtl/occ_dvfs_tick.sv
module occ_dvfs_tick #(
    parameter int PERIOD = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tick_s;

    tick_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.cnt == LAST);

endmodule

// File: rtl/occ_dvfs_decide.sv
module occ_dvfs_decide
    import occ_dvfs_pkg::*;
#(
    parameter int NUM_Q  = 2,
    parameter int OCC_W  = 8,
    parameter int THR_HI = 96,
    parameter int THR_LO = 32
) (
    input  logic                        sample_i,
    input  logic [NUM_Q-1:0][OCC_W-1:0] occ_i,
    output step_e                       step_o
);
    localparam logic [OCC_W-1:0] HI_V = OCC_W'(THR_HI);
    localparam logic [OCC_W-1:0] LO_V = OCC_W'(THR_LO);

    logic [NUM_Q-1:0] over_hi;
    logic [NUM_Q-1:0] under_lo;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_cmp
        assign over_hi[q]  = (occ_i[q] > HI_V);
        assign under_lo[q] = (occ_i[q] < LO_V);
    end

    always_comb begin
        step_o = STEP_HOLD;
        if (sample_i) begin
            if (&over_hi) begin
                step_o = STEP_UP;
            end else if (&under_lo) begin
                step_o = STEP_DOWN;
            end
        end
    end

endmodule

// File: rtl/occ_dvfs_level.sv
module occ_dvfs_level
    import occ_dvfs_pkg::*;
#(
    parameter int NUM_LEVELS  = 6,
    parameter int RESET_LEVEL = 5,
    parameter int SETTLE_CYC  = 10
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  step_e                         step_i,
    output logic [$clog2(NUM_LEVELS)-1:0] level_o,
    output logic                          busy_o
);
    localparam int LVL_W = $clog2(NUM_LEVELS);
    localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [LVL_W-1:0] TOP_LVL   = LVL_W'(NUM_LEVELS - 1);
    localparam logic [LVL_W-1:0] RST_LVL   = LVL_W'(RESET_LEVEL);
    localparam logic [SET_W-1:0] SET_START = SET_W'(SETTLE_CYC - 1);

    typedef struct packed {
        mode_e             mode;
        logic [LVL_W-1:0]  level;
        logic [SET_W-1:0]  settle;
    } lvl_s;

    lvl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MODE_IDLE: begin
                if (step_i == STEP_UP && st_q.level != TOP_LVL) begin
                    st_d.level  = st_q.level + 1'b1;
                    st_d.mode   = MODE_SETTLE;
                    st_d.settle = SET_START;
                end else if (step_i == STEP_DOWN && st_q.level != '0) begin
                    st_d.level  = st_q.level - 1'b1;
                    st_d.mode   = MODE_SETTLE;
                    st_d.settle = SET_START;
                end
            end
            MODE_SETTLE: begin
                if (st_q.settle == '0) begin
                    st_d.mode = MODE_IDLE;
                end else begin
                    st_d.settle = st_q.settle - 1'b1;
                end
            end
            default: st_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.mode   <= MODE_IDLE;
            st_q.level  <= RST_LVL;
            st_q.settle <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign busy_o  = (st_q.mode == MODE_SETTLE);

endmodule

// File: rtl/occ_dvfs_ctrl.sv
module occ_dvfs_ctrl
    import occ_dvfs_pkg::*;
#(
    parameter int QUEUE_DEPTH = 128,
    parameter int NUM_LEVELS  = 6,
    parameter int RESET_LEVEL = NUM_LEVELS - 1,
    parameter int REF_CLK_MHZ = 100,
    parameter int SAMPLE_NS   = 1000,
    parameter int SETTLE_NS   = 100,
    parameter int THR_HI      = 96,
    parameter int THR_LO      = 32
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic [$clog2(QUEUE_DEPTH+1)-1:0]     boq_occ_i,
    input  logic [$clog2(QUEUE_DEPTH+1)-1:0]     lvq_occ_i,
    output logic [$clog2(NUM_LEVELS)-1:0]        level_o,
    output logic                                 busy_o
);
    localparam int OCC_W      = $clog2(QUEUE_DEPTH + 1);
    localparam int NUM_Q      = 2;
    localparam int SAMPLE_CYC = ns_to_cycles(REF_CLK_MHZ, SAMPLE_NS);
    localparam int SETTLE_CYC = ns_to_cycles(REF_CLK_MHZ, SETTLE_NS);

    logic                        sample;
    logic [NUM_Q-1:0][OCC_W-1:0] occ;
    step_e                       step;

    assign occ[0] = boq_occ_i;
    assign occ[1] = lvq_occ_i;

    occ_dvfs_tick #(
        .PERIOD (SAMPLE_CYC)
    ) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (sample)
    );

    occ_dvfs_decide #(
        .NUM_Q  (NUM_Q),
        .OCC_W  (OCC_W),
        .THR_HI (THR_HI),
        .THR_LO (THR_LO)
    ) u_decide (
        .sample_i (sample),
        .occ_i    (occ),
        .step_o   (step)
    );

    occ_dvfs_level #(
        .NUM_LEVELS  (NUM_LEVELS),
        .RESET_LEVEL (RESET_LEVEL),
        .SETTLE_CYC  (SETTLE_CYC)
    ) u_level (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (step),
        .level_o (level_o),
        .busy_o  (busy_o)
    );

endmodule

// File: rtl/occ_dvfs_ctrl_chk.sv
module occ_dvfs_ctrl_chk #(
    parameter int NUM_LEVELS = 6,
    parameter int SETTLE_CYC = 10
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic [$clog2(NUM_LEVELS)-1:0] level_i,
    input logic                          busy_i
);
    // Length of the current busy run, counted in the checker
    int unsigned run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= 0;
        end else if (busy_i) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    // R9: index stays inside the level range
    a_r9_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(level_i) < NUM_LEVELS);

    // R9: each change moves exactly one step
    a_r9_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(level_i) |->
            (int'(level_i) == int'($past(level_i)) + 1) ||
            (int'(level_i) + 1 == int'($past(level_i))));

    // R7: a change raises busy in the same cycle
    a_r7_busy_with_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(level_i) |-> (busy_i && !$past(busy_i)));

    // R7: busy lasts exactly the settling count
    a_r7_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_i) |-> (run_q == SETTLE_CYC));

    // R8: no change while already settling
    a_r8_hold_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && $past(busy_i)) |-> $stable(level_i));

endmodule

bind occ_dvfs_ctrl occ_dvfs_ctrl_chk #(
    .NUM_LEVELS (NUM_LEVELS),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level_o),
    .busy_i  (busy_o)
);

// File: tb/occ_dvfs_ctrl_tb.sv
module occ_dvfs_ctrl_tb;
    localparam int DEPTH  = 128;
    localparam int NLVL   = 6;
    localparam int MHZ    = 100;
    localparam int S_NS   = 200;
    localparam int T_NS   = 300;
    localparam int HI     = 96;
    localparam int LO     = 32;
    localparam int S_CYC  = MHZ * S_NS / 1000;  // 20
    localparam int T_CYC  = MHZ * T_NS / 1000;  // 30
    localparam int OW     = $clog2(DEPTH + 1);
    localparam int LW     = $clog2(NLVL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [OW-1:0] boq = '0;
    logic [OW-1:0] lvq = '0;
    logic [LW-1:0] level;
    logic          busy;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    string tag = "R1";

    // Reference state, advanced on rising edges
    int m_ph   = 0;
    int m_lvl  = NLVL - 1;
    int m_wait = 0;

    always #5 clk = ~clk;

    occ_dvfs_ctrl #(
        .QUEUE_DEPTH (DEPTH),
        .NUM_LEVELS  (NLVL),
        .RESET_LEVEL (NLVL - 1),
        .REF_CLK_MHZ (MHZ),
        .SAMPLE_NS   (S_NS),
        .SETTLE_NS   (T_NS),
        .THR_HI      (HI),
        .THR_LO      (LO)
    ) u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .boq_occ_i (boq),
        .lvq_occ_i (lvq),
        .level_o   (level),
        .busy_o    (busy)
    );

    function automatic int want_step(input int a, input int b);
        if (a > HI && b > HI) return 1;
        if (a < LO && b < LO) return -1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_lvl = NLVL - 1; m_wait = 0;
        end else begin
            bit smp;
            int s;
            smp = (m_ph == S_CYC - 1);
            m_ph = smp ? 0 : m_ph + 1;
            if (m_wait > 0) begin
                m_wait = m_wait - 1;
            end else if (smp) begin
                s = want_step(int'(boq), int'(lvq));
                if (s == 1 && m_lvl < NLVL - 1) begin
                    m_lvl = m_lvl + 1; m_wait = T_CYC;
                end else if (s == -1 && m_lvl > 0) begin
                    m_lvl = m_lvl - 1; m_wait = T_CYC;
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tag, "level", int'(level), m_lvl);
            check(tag, "busy", int'(busy), (m_wait > 0) ? 1 : 0);
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drive(input int a, input int b);
        boq = OW'(a);
        lvq = OW'(b);
    endtask

    function automatic int pick_occ(input int kind);
        case (kind)
            0: return HI + 1 + int'($urandom_range(DEPTH - HI - 1));
            1: return int'($urandom_range(LO - 1));
            2: return HI;
            3: return LO;
            default: return int'($urandom_range(DEPTH));
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        drive(0, 0);
        cycles(4);
        check("R1", "reset level", int'(level), NLVL - 1);
        check("R1", "reset busy", int'(busy), 0);
        rst_n = 1'b1;

        // First sample at edge 20, ignored one at 40, next at 60
        tag = "R2";
        cycles(19);
        check("R2", "level before first sample", int'(level), NLVL - 1);
        cycles(1);
        check("R4", "level after first sample", int'(level), NLVL - 2);
        check("R7", "busy after change", int'(busy), 1);
        cycles(29);
        check("R7", "busy last cycle", int'(busy), 1);
        cycles(1);
        check("R7", "busy cleared", int'(busy), 0);
        check("R8", "sample during busy ignored", int'(level), NLVL - 2);
        cycles(10);
        check("R4", "second step", int'(level), NLVL - 3);

        // Walk to the bottom and stay there
        tag = "R6";
        cycles(300);
        check("R6", "bottom level", int'(level), 0);
        check("R6", "no busy at bottom", int'(busy), 0);

        // Exact thresholds and disagreement keep the level
        tag = "R5";
        drive(LO, LO);     cycles(60);
        drive(HI, HI);     cycles(60);
        drive(DEPTH, 10);  cycles(60);
        drive(5, DEPTH);   cycles(60);
        drive(HI + 1, HI); cycles(60);
        check("R5", "level held", int'(level), 0);

        // Climb to the top and saturate
        tag = "R3";
        drive(DEPTH, HI + 1);
        cycles(260);
        tag = "R6";
        cycles(80);
        check("R3", "top reached", int'(level), NLVL - 1);
        check("R6", "no busy at top", int'(busy), 0);

        // Random mix, inputs changing between samples too
        tag = "R2";
        for (int n = 0; n < 3000; n++) begin
            int ka, kb;
            ka = int'($urandom_range(4));
            kb = ($urandom_range(3) == 0) ? int'($urandom_range(4)) : ka;
            drive(pick_occ(ka), pick_occ(kb));
            cycles(1 + int'($urandom_range(7)));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule